// File: doc/BRIEF.md
# I2C Master Clock-Line Generator

This block produces the serial clock of an I2C master. A down-counter, reloaded from a 7-bit period value, times each half of the clock. The counter advances only on a machine-cycle enable strobe. The block drives the clock line through an open-drain style output: it either pulls the line low or lets it float. It reads the line back through a sampled input. A slave may hold the line low after the master has let it go. While that happens the counter stays frozen. When the line is finally seen high, the counter reloads, so the high half always gets its full length.

A controller raises `run` to start the clock and lowers it to stop. While stopped, the line is left released. The block has two strobes: one marks the cycle in which the line is first seen high after a release, and one marks the middle of each high half. SDA sequencing and the byte logic use these two strobes. A stretch flag shows when a slave is holding the clock.

The state machine has four states. IDLE releases the line and keeps loading the counter. LOW pulls the line low and counts down. WAIT releases the line, freezes the counter and waits for a high sample. HIGH releases the line and counts down. The transitions are:
- IDLE→LOW, on a machine cycle with `run` set.
- LOW→WAIT, on a rollover.
- WAIT→HIGH, on a machine cycle in which the line is sampled high. The counter reloads here.
- HIGH→LOW, on a rollover. The counter reloads here.
- Any state→IDLE, when `run` is low.

Top module: `scl_clock_gen`

## Requirements
- R1: After a synchronous reset, `scl_pull_low`, `rise_evt`, `high_mid` and `stretch` are all 0 and the block is in IDLE.
- R2: While `run` is 0, the line is released from the next clock on, and the counter keeps loading from `reload`. The first low half after `run` rises therefore uses the `reload` value present at that time.
- R3: The low half lasts `reload`+1 machine cycles, which is 4·(`reload`+1) clocks when the enable strobe comes every fourth clock.
- R4: A counter rollover during the low half releases the line (LOW→WAIT) on that machine cycle.
- R5: While the line is released but still sampled low, the counter holds its value and `stretch` is 1. `stretch` is 0 at all other times.
- R6: On the first machine cycle in which the released line is sampled high, `rise_evt` pulses for one clock and the counter reloads from `reload` (WAIT→HIGH).
- R7: The HIGH state lasts `reload`+1 machine cycles after the reload, then the line is pulled low again with a reload (HIGH→LOW). Without stretching, the line stays high for 4·(`reload`+2) clocks, including the WAIT cycle.
- R8: `high_mid` pulses for one clock, once per high half, on the HIGH machine cycle in which the counter equals `reload` shifted right by one.
- R9: A `reload` of 0 gives a rollover on every machine cycle: 1 machine cycle low and 2 high, repeating without lockup.
- R10: The state and the line drive change only on clocks where `tick` is 1 (except for the stop caused by `run`=0), so sampling and counting follow the machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Machine-cycle enable strobe |
| run | input | 1 | Clock generation enable |
| reload | input | 7 | Counter reload value for each half period |
| scl_in | input | 1 | Sampled level of the clock line |
| scl_pull_low | output | 1 | 1 pulls the line low, 0 releases it |
| high_mid | output | 1 | One-clock strobe in the middle of a high half |
| rise_evt | output | 1 | One-clock strobe when the line is first seen high after a release |
| stretch | output | 1 | Line released but still held low by another device |

## Verification
The assertions check these rules on every cycle:
- The state changes only on a machine-cycle strobe.
- The counter stays frozen while a released line reads low, and `stretch` is set exactly then.
- A reload follows the first high sample, and each count step is exactly one.
- The line is released one clock after `run` falls.
- `high_mid` appears only while the line reads high.

Only the bench scenarios can show the full timing. They measure the low and high durations for several reload values, including 0 and 127. They also show that a high half after a slave stretch still gets its full length, and that a new reload value takes effect when the clock is restarted.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    // Clock generator phase states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // stopped, line released, counter tracks reload
        ST_LOW  = 2'd1,   // line pulled low, counting
        ST_WAIT = 2'd2,   // line released, counter frozen until high sample
        ST_HIGH = 2'd3    // line released and high, counting
    } scl_state_t;

endpackage

// File: rtl/sclgen_baud.sv
module sclgen_baud #(
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic             dec_en,
    input  logic [RLD_W-1:0] reload,
    output logic [RLD_W-1:0] count,
    output logic             zero,
    output logic             at_half
);

    logic [RLD_W-1:0] half_val;

    assign half_val = reload >> 1;
    assign zero     = (count == '0);
    assign at_half  = (count == half_val);

    // Load wins over decrement; decrement only on the machine-cycle strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= reload;
        end else if (tick && dec_en && !zero) begin
            count <= count - 1'b1;
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(reload))); // R6

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && dec_en && !load && !zero) |=> (count == $past(count) - 1'b1)); // R3

    AST_NO_DRIFT: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count)); // R10

endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       scl_in,
    input  logic       cnt_zero,
    input  logic       cnt_half,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       pull_low,
    output logic       rise_pulse,
    output logic       mid_pulse,
    output logic       stretch_flag,
    output scl_state_t state_o
);

    scl_state_t state_q;
    scl_state_t state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run && tick) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!run)                 state_d = ST_IDLE;
                else if (tick && cnt_zero) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!run)                 state_d = ST_IDLE;
                else if (tick && scl_in)  state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!run)                 state_d = ST_IDLE;
                else if (tick && cnt_zero) state_d = ST_LOW;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Outputs and counter controls
    always_comb begin
        cnt_load     = 1'b0;
        cnt_dec      = 1'b0;
        pull_low     = 1'b0;
        rise_pulse   = 1'b0;
        mid_pulse    = 1'b0;
        stretch_flag = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_load = 1'b1;
            end
            ST_LOW: begin
                pull_low = 1'b1;
                cnt_dec  = 1'b1;
            end
            ST_WAIT: begin
                stretch_flag = !scl_in;
                if (run && tick && scl_in) begin
                    cnt_load   = 1'b1;
                    rise_pulse = 1'b1;
                end
            end
            ST_HIGH: begin
                cnt_dec   = 1'b1;
                mid_pulse = tick && cnt_half;
                if (run && tick && cnt_zero) cnt_load = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        !run |=> !pull_low); // R2

    AST_TICK_PACED: assert property (@(posedge clk) disable iff (rst)
        (!tick && run) |=> $stable(state_q)); // R10

    AST_FROZEN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !scl_in) |=> (state_q != ST_HIGH)); // R5

    AST_MID_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mid_pulse |-> scl_in); // R8

    AST_RISE_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> (state_q == ST_HIGH)); // R6

    AST_LOW_EXIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOW && run && tick && cnt_zero) |=> !pull_low); // R4

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
    parameter int RLD_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             high_mid,
    output logic             rise_evt,
    output logic             stretch
);
    import sclgen_pkg::*;

    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             cnt_half;
    logic [RLD_W-1:0] cnt_val;
    scl_state_t       cur_state;

    sclgen_baud #(.RLD_W(RLD_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (cnt_load),
        .dec_en  (cnt_dec),
        .reload  (reload),
        .count   (cnt_val),
        .zero    (cnt_zero),
        .at_half (cnt_half)
    );

    sclgen_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .run          (run),
        .scl_in       (scl_in),
        .cnt_zero     (cnt_zero),
        .cnt_half     (cnt_half),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .pull_low     (scl_pull_low),
        .rise_pulse   (rise_evt),
        .mid_pulse    (high_mid),
        .stretch_flag (stretch),
        .state_o      (cur_state)
    );

    AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_WAIT && !scl_in) |=> $stable(cnt_val)); // R5

    AST_STRETCH_FLAG: assert property (@(posedge clk) disable iff (rst)
        stretch |-> (!scl_in && !scl_pull_low)); // R5

    AST_IDLE_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IDLE) |=> (cnt_val == $past(reload))); // R2

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       run = 1'b0;
    logic [6:0] reload = 7'd5;
    logic       hold = 1'b0;
    logic       scl_line;
    logic       scl_pull_low, high_mid, rise_evt, stretch;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // Open-drain line model: low if the master pulls or a slave holds
    assign scl_line = ~scl_pull_low & ~hold;

    scl_clock_gen uut (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .run          (run),
        .reload       (reload),
        .scl_in       (scl_line),
        .scl_pull_low (scl_pull_low),
        .high_mid     (high_mid),
        .rise_evt     (rise_evt),
        .stretch      (stretch)
    );

    // Machine-cycle strobe: one clock in four
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph  = (ph + 1) % 4;
            tick = (ph == 0);
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait until the line drive turns on (start of a low half)
    task automatic wait_low_start();
        int guard = 0;
        while (scl_pull_low && guard < 2000) begin step(); guard++; end
        while (!scl_pull_low && guard < 4000) begin step(); guard++; end
    endtask

    // Count clocks of drive low, starting at the first low clock
    task automatic measure_low(output int n);
        n = 0;
        while (scl_pull_low && n < 4000) begin n++; step(); end
    endtask

    // Count clocks of line high plus the strobes seen during them
    task automatic measure_high(output int n, output int rises, output int mids);
        n = 0; rises = 0; mids = 0;
        while (scl_line && n < 4000) begin
            n++;
            if (rise_evt) rises++;
            if (high_mid) mids++;
            step();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b0; hold = 1'b0;
        repeat (6) step();
        check(!scl_pull_low && !rise_evt && !high_mid && !stretch, "R1",
              "outputs after reset", {scl_pull_low, rise_evt, high_mid, stretch}, 0);
        rst = 1'b0;
        step();
    endtask

    task automatic t_stopped();
        int lows = 0;
        run = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (scl_pull_low) lows++;
        end
        check(lows == 0, "R2", "drive cycles while stopped", lows, 0);
    endtask

    task automatic t_normal(input int r);
        int nl, nh, ri, mi;
        reload = 7'(r);
        run = 1'b1;
        wait_low_start();
        measure_low(nl);
        check(nl == 4 * (r + 1), "R3", "low clocks", nl, 4 * (r + 1));
        check(!scl_pull_low, "R4", "released after rollover", scl_pull_low, 0);
        measure_high(nh, ri, mi);
        check(nh == 4 * (r + 2), "R7", "high clocks", nh, 4 * (r + 2));
        check(ri == 1, "R6", "rise strobes per high", ri, 1);
        check(mi == 1, "R8", "mid strobes per high", mi, 1);
        check(scl_pull_low, "R7", "drive low after high", scl_pull_low, 1);
    endtask

    task automatic t_mid_position(input int r);
        int gap = 0;
        int guard = 0;
        reload = 7'(r);
        run = 1'b1;
        while (!rise_evt && guard < 4000) begin step(); guard++; end
        while (!high_mid && gap < 4000) begin step(); gap++; end
        check(gap == 4 * (r - r / 2 + 1), "R8", "clocks from rise to mid",
              gap, 4 * (r - r / 2 + 1));
    endtask

    task automatic t_stretch();
        int sflag = 0, bad = 0, nh, ri, mi, guard = 0;
        reload = 7'd3;
        run = 1'b1;
        wait_low_start();
        hold = 1'b1;
        while (scl_pull_low && guard < 4000) begin step(); guard++; end
        for (int i = 0; i < 40; i++) begin
            if (stretch) sflag++;
            if (scl_pull_low || rise_evt) bad++;
            step();
        end
        check(sflag == 40, "R5", "stretch flag cycles", sflag, 40);
        check(bad == 0, "R5", "no drive or rise while held", bad, 0);
        hold = 1'b0;
        #1;
        measure_high(nh, ri, mi);
        check(nh >= 4 * 4 + 1 && nh <= 4 * 5, "R5", "full high after stretch", nh, 4 * 5);
        check(ri == 1 && mi == 1, "R6", "strobes after stretch", ri + mi, 2);
        check(!stretch, "R5", "stretch flag clear when driving", stretch, 0);
    endtask

    task automatic t_zero();
        int nl, nh, ri, mi, okc = 0;
        reload = 7'd0;
        run = 1'b1;
        wait_low_start();
        for (int k = 0; k < 5; k++) begin
            measure_low(nl);
            measure_high(nh, ri, mi);
            if (nl == 4 && nh == 8 && ri == 1 && mi == 1) okc++;
        end
        check(okc == 5, "R9", "good periods with zero reload", okc, 5);
    endtask

    task automatic t_stop_restart();
        int lows = 0, nl;
        reload = 7'd6;
        run = 1'b1;
        wait_low_start();
        repeat (5) step();
        run = 1'b0;
        step();
        check(!scl_pull_low, "R2", "released after stop", scl_pull_low, 0);
        reload = 7'd2;
        for (int i = 0; i < 30; i++) begin
            step();
            if (scl_pull_low) lows++;
        end
        check(lows == 0, "R2", "no drive while stopped", lows, 0);
        run = 1'b1;
        wait_low_start();
        measure_low(nl);
        check(nl == 12, "R2", "low clocks with new reload", nl, 12);
    endtask

    task automatic t_pacing();
        int odd = 0;
        bit prev_drive;
        bit prev_tick;
        reload = 7'd1;
        run = 1'b1;
        step();
        prev_drive = scl_pull_low;
        prev_tick  = tick;
        for (int i = 0; i < 200; i++) begin
            step();
            if (scl_pull_low != prev_drive && !prev_tick) odd++;
            prev_drive = scl_pull_low;
            prev_tick  = tick;
        end
        check(odd == 0, "R10", "drive changes off the strobe", odd, 0);
    endtask

    task automatic t_max();
        int nl;
        reload = 7'd127;
        run = 1'b1;
        wait_low_start();
        measure_low(nl);
        check(nl == 512, "R3", "low clocks at max reload", nl, 512);
    endtask

    initial begin
        t_reset();
        t_stopped();
        t_normal(5);
        t_normal(2);
        t_mid_position(5);
        t_mid_position(8);
        t_stretch();
        t_zero();
        t_stop_restart();
        t_pacing();
        t_max();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule